// File: doc/BRIEF.md
# File-Register Instruction Execute Unit

This block executes a narrow slice of a 14-bit instruction set for an 8-bit accumulator-style core. It holds a 128-byte register file, the working register W, a zero flag, two status bits for timeout and power-down, and a free-running watchdog made of a prescaler and a counter. Instruction words arrive on a valid/ready stream. Each accepted word executes on the clock edge that accepts it.

Three register operations are supported: complement, decrement, and decrement with a skip on zero. A destination bit in each of them routes the result either to W or back into the addressed register. The unit also supports the clear-watchdog word.

Fetch is modelled as one stage ahead of execution. A taken skip therefore throws away the next accepted word, and that word's slot counts as a no-operation. The program counter, W, the flags, the watchdog state and a debug read port into the register file are all visible at the ports.

Top module: `fr_exec_unit`

## Requirements
- R1: While reset is asserted (rst_n low) and right after it, PC, W, the zero flag, the watchdog counter, the prescaler and every register-file entry are 0, and the timeout and power-down bits are 1.
- R2: A register operation has the form word[13:12]=00, opcode in word[11:8], destination bit in word[7], address f in word[6:0]. With destination 0 the result goes to W and register f is unchanged. With destination 1 the result goes to register f and W is unchanged.
- R3: Opcode 1001 writes the bitwise complement of register f. The zero flag becomes 1 exactly when that result is 0x00.
- R4: Opcode 0011 writes register f minus one, modulo 256, so 0x00 gives 0xFF. The zero flag becomes 1 exactly when the result is 0x00.
- R5: Opcode 1011 writes register f minus one, modulo 256, and leaves the zero flag unchanged.
- R6: When opcode 1011 yields 0x00, the next accepted word is discarded and changes no state other than PC. Any number of idle cycles may come in between. PC still advances by one for the discarded word.
- R7: The word 0x0064 clears the watchdog counter and the prescaler, and sets the timeout and power-down bits to 1.
- R8: Any other word is a no-operation. It changes nothing but PC.
- R9: in_ready is always 1. PC advances by one, modulo 2^13, on each clock where in_valid is 1, and holds when in_valid is 0.
- R10: The prescaler (3 bits by default) increments on every clock. The watchdog counter increments on each clock where the prescaler wraps from its maximum. A clear-watchdog word takes priority over both increments in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Word accepted; tied to 1, so there is no back-pressure |
| in_word | input | 14 | Instruction word |
| dbg_addr | input | 7 | Register-file debug read address |
| dbg_data | output | 8 | Register-file contents at dbg_addr (combinational) |
| pc_o | output | 13 | Program counter |
| w_o | output | 8 | Working register W |
| z_o | output | 1 | Zero flag |
| to_o | output | 1 | Timeout status bit |
| pd_o | output | 1 | Power-down status bit |
| wdt_cnt_o | output | 8 | Watchdog counter |
| wdt_presc_o | output | 3 | Watchdog prescaler |

## Verification
Every architectural result of an accepted word is due one clock after the acceptance edge: W, the flag, register f, PC and the watchdog state. The debug read follows dbg_addr within the same cycle. The bench steps a behavioural model on each rising edge and compares all outputs 2 ns later, so every result is checked in exactly the cycle it is due. Inputs change only on falling edges. A discarded slot is checked the cycle after its acceptance, whether it follows the skip directly or after idle gaps.

// File: rtl/fr_pkg.sv
package fr_pkg;
  localparam int INSTR_W = 14;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 7;
  localparam int OPC_W   = 4;

  localparam logic [OPC_W-1:0]   OPC_COMF   = 4'b1001;
  localparam logic [OPC_W-1:0]   OPC_DECF   = 4'b0011;
  localparam logic [OPC_W-1:0]   OPC_DECFSZ = 4'b1011;
  localparam logic [INSTR_W-1:0] WORD_CLRWDT = 14'h0064;

  typedef enum logic [2:0] {
    OP_NOP,
    OP_COMF,
    OP_DECF,
    OP_DECFSZ,
    OP_CLRWDT
  } op_e;

  typedef struct packed {
    op_e               op;
    logic              to_file;
    logic [ADDR_W-1:0] addr;
  } dec_t;
endpackage

// File: rtl/fr_decode.sv
module fr_decode
  import fr_pkg::*;
(
  input  logic [INSTR_W-1:0] word_i,
  output dec_t               dec_o
);
  logic             byte_form;
  logic [OPC_W-1:0] opc;

  assign byte_form = (word_i[INSTR_W-1 -: 2] == 2'b00);
  assign opc       = word_i[INSTR_W-3 -: OPC_W];

  always_comb begin
    dec_o.op      = OP_NOP;
    dec_o.to_file = word_i[ADDR_W];
    dec_o.addr    = word_i[ADDR_W-1:0];
    if (word_i == WORD_CLRWDT) begin
      dec_o.op = OP_CLRWDT;
    end else if (byte_form) begin
      unique case (opc)
        OPC_COMF:   dec_o.op = OP_COMF;
        OPC_DECF:   dec_o.op = OP_DECF;
        OPC_DECFSZ: dec_o.op = OP_DECFSZ;
        default:    dec_o.op = OP_NOP;
      endcase
    end
  end
endmodule

// File: rtl/fr_regfile.sv
module fr_regfile #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata_a = mem_q[raddr_a];
  assign rdata_b = mem_q[raddr_b];

  AST_RF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem_q[$past(waddr)] == $past(wdata)); // R2
endmodule

// File: rtl/fr_wdt.sv
module fr_wdt #(
  parameter int PRESC_W = 3,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  output logic [PRESC_W-1:0] presc_o,
  output logic [CNT_W-1:0]   cnt_o
);
  localparam logic [PRESC_W-1:0] PRESC_MAX = '1;

  logic [PRESC_W-1:0] presc_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               carry;

  assign carry = (presc_q == PRESC_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      presc_q <= '0;
      cnt_q   <= '0;
    end else begin
      presc_q <= presc_q + PRESC_W'(1);
      if (carry) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign presc_o = presc_q;
  assign cnt_o   = cnt_q;

  AST_WDT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && presc_q == PRESC_MAX) |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R10
  AST_WDT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && presc_q != PRESC_MAX) |=> $stable(cnt_q)); // R10
  AST_WDT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (presc_q == '0) && (cnt_q == '0)); // R7
endmodule

// File: rtl/fr_exec_unit.sv
module fr_exec_unit
  import fr_pkg::*;
#(
  parameter int PC_W    = 13,
  parameter int PRESC_W = 3,
  parameter int WDT_W   = 8,
  parameter int DEPTH   = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [INSTR_W-1:0] in_word,
  input  logic [ADDR_W-1:0]  dbg_addr,
  output logic [DATA_W-1:0]  dbg_data,
  output logic [PC_W-1:0]    pc_o,
  output logic [DATA_W-1:0]  w_o,
  output logic               z_o,
  output logic               to_o,
  output logic               pd_o,
  output logic [WDT_W-1:0]   wdt_cnt_o,
  output logic [PRESC_W-1:0] wdt_presc_o
);
  dec_t              dec;
  logic              exec;
  logic              is_file_op;
  logic [DATA_W-1:0] src;
  logic [DATA_W-1:0] result;
  logic              res_zero;
  logic              rf_we;
  logic              wdt_clr;

  logic [PC_W-1:0]   pc_q;
  logic [DATA_W-1:0] w_q;
  logic              z_q;
  logic              to_q;
  logic              pd_q;
  logic              skip_q;

  assign in_ready = 1'b1;

  fr_decode u_dec (
    .word_i (in_word),
    .dec_o  (dec)
  );

  fr_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (rf_we),
    .waddr   (dec.addr),
    .wdata   (result),
    .raddr_a (dec.addr),
    .rdata_a (src),
    .raddr_b (dbg_addr),
    .rdata_b (dbg_data)
  );

  fr_wdt #(.PRESC_W(PRESC_W), .CNT_W(WDT_W)) u_wdt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (wdt_clr),
    .presc_o (wdt_presc_o),
    .cnt_o   (wdt_cnt_o)
  );

  // A word accepted while a skip is pending occupies a slot but does nothing.
  assign exec       = in_valid && !skip_q;
  assign is_file_op = (dec.op == OP_COMF) || (dec.op == OP_DECF) || (dec.op == OP_DECFSZ);
  assign result     = (dec.op == OP_COMF) ? ~src : (src - DATA_W'(1));
  assign res_zero   = (result == '0);
  assign rf_we      = exec && is_file_op && dec.to_file;
  assign wdt_clr    = exec && (dec.op == OP_CLRWDT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      w_q    <= '0;
      z_q    <= 1'b0;
      to_q   <= 1'b1;
      pd_q   <= 1'b1;
      skip_q <= 1'b0;
    end else begin
      if (in_valid) begin
        pc_q   <= pc_q + PC_W'(1);
        skip_q <= exec && (dec.op == OP_DECFSZ) && res_zero;
      end
      if (exec && is_file_op && !dec.to_file) w_q <= result;
      if (exec && ((dec.op == OP_COMF) || (dec.op == OP_DECF))) z_q <= res_zero;
      if (wdt_clr) begin
        to_q <= 1'b1;
        pd_q <= 1'b1;
      end
    end
  end

  assign pc_o = pc_q;
  assign w_o  = w_q;
  assign z_o  = z_q;
  assign to_o = to_q;
  assign pd_o = pd_q;

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> pc_q == $past(pc_q) + PC_W'(1)); // R9
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(pc_q)); // R9
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && skip_q) |=> $stable(w_q) && $stable(z_q) && !skip_q); // R6
  AST_FLUSH_WDT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && skip_q && in_word == WORD_CLRWDT && wdt_presc_o != '1)
      |=> wdt_presc_o == $past(wdt_presc_o) + PRESC_W'(1)); // R6
  AST_DSZ_ZHOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && dec.op == OP_DECFSZ) |=> $stable(z_q)); // R5
  AST_CLR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |=> to_q && pd_q && (wdt_cnt_o == '0)); // R7
  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && dec.op == OP_NOP) |=> $stable(w_q) && $stable(z_q) && !skip_q); // R8
endmodule

// File: tb/fr_exec_unit_bench.sv
module fr_exec_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [13:0] in_word;
  logic [6:0]  dbg_addr;
  logic [7:0]  dbg_data;
  logic [12:0] pc_o;
  logic [7:0]  w_o;
  logic        z_o, to_o, pd_o;
  logic [7:0]  wdt_cnt_o;
  logic [2:0]  wdt_presc_o;

  always #4 clk = ~clk;

  fr_exec_unit u_fr_exec_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .dbg_addr(dbg_addr), .dbg_data(dbg_data),
    .pc_o(pc_o), .w_o(w_o), .z_o(z_o), .to_o(to_o), .pd_o(pd_o),
    .wdt_cnt_o(wdt_cnt_o), .wdt_presc_o(wdt_presc_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit cmp_on = 0;
  bit done = 0;

  // behavioural reference state
  int m_rf[128];
  int m_pc, m_w, m_z, m_to, m_pd, m_skip, m_presc, m_cnt;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  function automatic logic [13:0] mk(logic [3:0] opc, logic d, logic [6:0] f);
    return {2'b00, opc, d, f};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_rf[i]) m_rf[i] = 0;
      m_pc = 0; m_w = 0; m_z = 0; m_to = 1; m_pd = 1;
      m_skip = 0; m_presc = 0; m_cnt = 0;
    end else begin
      if (m_presc == 7) m_cnt = (m_cnt + 1) % 256;
      m_presc = (m_presc + 1) % 8;
      if (in_valid) begin
        m_pc = (m_pc + 1) % 8192;
        if (m_skip != 0) begin
          m_skip = 0;
        end else begin
          int f, v, r;
          f = int'(in_word[6:0]);
          v = m_rf[f];
          if (in_word == 14'h0064) begin
            m_presc = 0; m_cnt = 0; m_to = 1; m_pd = 1;
          end else if (in_word[13:12] == 2'b00 &&
                       (in_word[11:8] == 4'h9 || in_word[11:8] == 4'h3 || in_word[11:8] == 4'hB)) begin
            r = (in_word[11:8] == 4'h9) ? (255 - v) : ((v + 255) % 256);
            if (in_word[7]) m_rf[f] = r; else m_w = r;
            if (in_word[11:8] != 4'hB) m_z = (r == 0) ? 1 : 0;
            else m_skip = (r == 0) ? 1 : 0;
          end
        end
      end
    end
  end

  // per-cycle comparison, 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (cmp_on && !done) begin
      chk("R9 pc", pc_o, m_pc);
      chk("R9 in_ready", in_ready, 1);
      chk("R2 W", w_o, m_w);
      chk("R3 R4 zero flag", z_o, m_z);
      chk("R7 timeout bit", to_o, m_to);
      chk("R7 power-down bit", pd_o, m_pd);
      chk("R10 watchdog count", wdt_cnt_o, m_cnt);
      chk("R10 prescaler", wdt_presc_o, m_presc);
      chk("R2 regfile read", dbg_data, m_rf[dbg_addr]);
    end
  end

  task automatic issue(logic [13:0] w);
    @(negedge clk);
    in_valid = 1'b1; in_word = w; dbg_addr = w[6:0];
    @(posedge clk); #3;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
    @(posedge clk); #3;
  endtask

  task automatic peek(logic [6:0] a);
    @(negedge clk);
    in_valid = 1'b0; dbg_addr = a;
    #1;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired (R9) got 0 exp 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; dbg_addr = 7'd5;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 pc", pc_o, 0);  chk("R1 W", w_o, 0);  chk("R1 zero", z_o, 0);
    chk("R1 timeout", to_o, 1); chk("R1 power-down", pd_o, 1);
    chk("R1 count", wdt_cnt_o, 0); chk("R1 prescaler", wdt_presc_o, 0);
    chk("R1 regfile", dbg_data, 0);
    @(negedge clk); rst_n = 1'b1; cmp_on = 1;

    issue(mk(4'h9, 1'b1, 7'd5));               // R3 complement into file
    chk("R3 comf file", dbg_data, 8'hFF); chk("R3 z clear", z_o, 0);
    issue(mk(4'h9, 1'b0, 7'd5));               // R2 dest W
    chk("R2 comf to W", w_o, 8'h00); chk("R3 z set", z_o, 1);
    chk("R2 file kept", dbg_data, 8'hFF);
    issue(mk(4'h3, 1'b1, 7'd5));               // R4
    chk("R4 decf file", dbg_data, 8'hFE); chk("R4 z clear", z_o, 0);
    issue(mk(4'h3, 1'b0, 7'd6));               // R4 wrap into W
    chk("R4 decf wrap", w_o, 8'hFF); chk("R2 file untouched", dbg_data, 8'h00);
    issue(mk(4'h9, 1'b1, 7'd8));
    issue(mk(4'h3, 1'b1, 7'd8));
    issue(mk(4'h9, 1'b1, 7'd8));
    chk("R3 build 01", dbg_data, 8'h01);
    issue(mk(4'hB, 1'b1, 7'd8));               // R5 skip taken
    chk("R5 decfsz file", dbg_data, 8'h00); chk("R5 z unchanged", z_o, 0);
    issue(mk(4'h9, 1'b1, 7'd9));               // R6 flushed
    chk("R6 flushed no write", dbg_data, 8'h00); chk("R6 pc advances", pc_o, 13'd9);
    issue(mk(4'h9, 1'b1, 7'd9));
    chk("R6 next executes", dbg_data, 8'hFF);
    idle(20);
    chk("R9 pc holds", pc_o, 13'd10);
    issue(14'h0064);                           // R7
    chk("R7 count cleared", wdt_cnt_o, 0); chk("R7 prescaler cleared", wdt_presc_o, 0);
    chk("R7 timeout", to_o, 1); chk("R7 power-down", pd_o, 1);
    issue(14'h3FFF); issue(14'h0000); issue(mk(4'h7, 1'b1, 7'd5));  // R8
    chk("R8 W kept", w_o, 8'hFF); chk("R8 file kept", dbg_data, 8'hFE);
    issue(mk(4'h9, 1'b1, 7'd10)); issue(mk(4'h3, 1'b1, 7'd10)); issue(mk(4'h9, 1'b1, 7'd10));
    issue(mk(4'hB, 1'b0, 7'd10));              // R5 to W, skip pending
    chk("R5 decfsz to W", w_o, 8'h00); chk("R5 file kept", dbg_data, 8'h01);
    idle(3);
    issue(mk(4'h9, 1'b0, 7'd10));              // R6 flushed after gap
    chk("R6 flushed after idle", w_o, 8'h00);
    issue(14'h0064);                           // R6 cleared skip, R7 runs
    chk("R7 clear after flush", wdt_presc_o, 0);
    idle(30);                                  // R10 count advances
    chk("R10 count after idle", wdt_cnt_o, 8'd3);

    for (int i = 0; i < 600; i++) begin
      logic [3:0] opc;
      int sel;
      sel = $urandom_range(0, 9);
      case (sel)
        0, 1:    opc = 4'h9;
        2, 3:    opc = 4'h3;
        4, 5, 6: opc = 4'hB;
        default: opc = 4'h5;
      endcase
      @(negedge clk);
      in_valid = ($urandom_range(0, 3) != 0);
      if (sel == 9) in_word = 14'h0064;
      else          in_word = mk(opc, 1'($urandom_range(0, 1)), 7'($urandom_range(0, 3)));
      dbg_addr = 7'($urandom_range(0, 3));
    end
    @(negedge clk); in_valid = 1'b0;
    peek(7'd0); peek(7'd1);
    @(posedge clk); #3;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule